// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between an internal request port and an external asynchronous static RAM of 128K bytes. A requester offers a single read or write with a valid/ready handshake. The controller registers the address and write data, then plays out a timed strobe sequence on the memory pins. The memory has an active-low select and an active-high select, an active-low output enable and an active-low write enable. Read data is sampled into a register and returned with a one-cycle response pulse.

Every timing minimum of the memory is a nanosecond parameter. The controller rounds each one up to whole clock cycles against a clock-period parameter. At the default 5 ns clock this gives a 14-cycle read strobe, an 11-cycle write pulse, a 14-cycle write occupancy and a 5-cycle bus-release turnaround after each read. The data bus is split into an output, a drive enable and an input, so that a pad cell can be placed outside the block. A parameter chooses whether the memory is deselected, and so in standby, whenever the controller is idle.

Top module: `async_sram_ctrl`

## Requirements
- R1: During and after reset, until the first request: `req_ready`=1, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `rsp_valid`=0. With the default idle-deselect setting, `mem_ce1_n`=1 and `mem_ce2`=0.
- R2: `mem_we_n` or `mem_oe_n` is low only while the memory is selected (`mem_ce1_n`=0 and `mem_ce2`=1).
- R3: An accepted read (`req_write`=0) drives `mem_oe_n` low, with `mem_we_n` high, for exactly 14 cycles, starting at the accepting edge. `rsp_valid` is a one-cycle pulse that rises at the 14th rising edge after the accepting edge. `rsp_rdata` then carries the byte that `mem_dq_in` held at that edge, which is the byte at the requested address.
- R4: An accepted write (`req_write`=1) first spends one cycle with the memory selected and `mem_we_n` high. It then holds `mem_we_n` low for exactly 11 consecutive cycles.
- R5: While `mem_we_n` is low, `mem_oe_n` stays high, and `mem_addr` and `mem_dq_out` do not change. `mem_dq_oe` is high only while `mem_we_n` is low.
- R6: After an accepted write, `req_ready` stays low for exactly 14 cycles. No other request is taken in that time.
- R7: After an accepted read, `req_ready` stays low for exactly 19 cycles. That is 5 cycles with `mem_oe_n` high after the capture edge, before a following write can begin.
- R8: When `IDLE_DESELECT`=0, an idle controller keeps the memory selected (`mem_ce1_n`=0, `mem_ce2`=1) with `mem_oe_n` and `mem_we_n` high. When `IDLE_DESELECT`=1, an idle controller deselects it (`mem_ce1_n`=1, `mem_ce2`=0).
- R9: `rsp_rdata` keeps its value until the next read capture, across any intervening writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle; request taken when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 8 | Captured read data, held |
| mem_addr | output | 17 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data to the pad |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | 8 | Data from the pad |

## Verification
The assertions assume that reset is held high for at least one clock edge before any request. They also assume that `mem_dq_in` is only sampled as meaningful at the capture edge, so its value at other times is unconstrained. The bench keeps within these assumptions by releasing reset only after several cycles. It offers each request at a falling edge while `req_ready` is high, and drops it after the accepting edge. The bench's memory model returns a marker byte whenever it is not enabled to drive, so a capture at the wrong time shows up as wrong data.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD,
        PH_RTURN,
        PH_WSETUP,
        PH_WPULSE,
        PH_WEND
    } phase_e;

    typedef struct packed {
        logic sel;
        logic oe_n;
        logic we_n;
        logic drv;
    } strobe_t;

    // Round a nanosecond figure up to whole clock cycles.
    function automatic int ns2cyc(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels for the phase the sequencer is entering.
    function automatic strobe_t phase_pins(input phase_e ph, input logic idle_sel);
        strobe_t s;
        s.sel  = (ph != PH_IDLE) ? 1'b1 : idle_sel;
        s.oe_n = (ph != PH_RD);
        s.we_n = (ph != PH_WPULSE);
        s.drv  = (ph == PH_WPULSE);
        return s;
    endfunction

endpackage

// File: rtl/sramc_sequencer.sv
`timescale 1ns/1ps
module sramc_sequencer
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC        = 14,
    parameter int WE_CYC        = 11,
    parameter int WEND_CYC      = 2,
    parameter int TURN_CYC      = 5,
    parameter bit IDLE_DESELECT = 1'b1,
    parameter int CNT_W         = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    start_wr,
    output logic    idle,
    output logic    capture,
    output strobe_t pins
);

    logic    idle_sel;
    phase_e  ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    strobe_t pins_q;

    generate
        if (IDLE_DESELECT) begin : g_idle_off
            assign idle_sel = 1'b0;
        end else begin : g_idle_on
            assign idle_sel = 1'b1;
        end
    endgenerate

    always_comb begin
        ph_d    = ph_q;
        cnt_d   = cnt_q;
        capture = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (start) begin
                    if (start_wr) begin
                        ph_d  = PH_WSETUP;
                        cnt_d = '0;
                    end else begin
                        ph_d  = PH_RD;
                        cnt_d = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            PH_RD: begin
                if (cnt_q == '0) begin
                    capture = 1'b1;
                    ph_d    = PH_RTURN;
                    cnt_d   = CNT_W'(TURN_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_RTURN: begin
                if (cnt_q == '0) ph_d = PH_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
            PH_WSETUP: begin
                ph_d  = PH_WPULSE;
                cnt_d = CNT_W'(WE_CYC - 1);
            end
            PH_WPULSE: begin
                if (cnt_q == '0) begin
                    ph_d  = PH_WEND;
                    cnt_d = CNT_W'(WEND_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_WEND: begin
                if (cnt_q == '0) ph_d = PH_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            pins_q <= phase_pins(PH_IDLE, idle_sel);
        end else begin
            ph_q   <= ph_d;
            cnt_q  <= cnt_d;
            pins_q <= phase_pins(ph_d, idle_sel);
        end
    end

    assign idle = (ph_q == PH_IDLE);
    assign pins = pins_q;

    assert_strobe_needs_select_R2: assert property (@(posedge clk) disable iff (rst)
        (!pins_q.we_n || !pins_q.oe_n) |-> pins_q.sel);
    assert_no_read_during_write_R3: assert property (@(posedge clk) disable iff (rst)
        !pins_q.oe_n |-> pins_q.we_n);
    assert_oe_off_in_write_R5: assert property (@(posedge clk) disable iff (rst)
        !pins_q.we_n |-> pins_q.oe_n);
    assert_drive_only_we_low_R5: assert property (@(posedge clk) disable iff (rst)
        pins_q.drv |-> !pins_q.we_n);
    assert_ready_pins_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        idle |-> (pins_q.we_n && pins_q.oe_n && !pins_q.drv));
    assert_we_rise_to_busy_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_q.we_n) |-> !idle);

endmodule

// File: rtl/sramc_datapath.sv
`timescale 1ns/1ps
module sramc_datapath #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] rdata,
    output logic          rsp_valid
);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            if (load) begin
                addr_q  <= ld_addr;
                wdata_q <= ld_data;
            end
            if (capture) rdata_q <= dq_in;
            rsp_q <= capture;
        end
    end

    assign addr      = addr_q;
    assign dq_out    = wdata_q;
    assign rdata     = rdata_q;
    assign rsp_valid = rsp_q;

    assert_rsp_single_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_q |=> !rsp_q);

endmodule

// File: rtl/async_sram_ctrl.sv
`timescale 1ns/1ps
module async_sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int AW            = 17,
    parameter int DW            = 8,
    parameter int CLK_NS        = 5,
    parameter int T_ADDR_ACC_NS = 70,
    parameter int T_OE_ACC_NS   = 35,
    parameter int T_RD_CYC_NS   = 70,
    parameter int T_WR_CYC_NS   = 70,
    parameter int T_WE_PW_NS    = 50,
    parameter int T_SEL_WEND_NS = 60,
    parameter int T_D_SETUP_NS  = 30,
    parameter int T_OE_REL_NS   = 25,
    parameter bit IDLE_DESELECT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce1_n,
    output logic          mem_ce2,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);

    // Address, selects and output enable change on the same edge, so the
    // read strobe spans the longest of the three read minimums.
    localparam int RD_CYC = imax(imax(ns2cyc(T_ADDR_ACC_NS, CLK_NS),
                                      ns2cyc(T_OE_ACC_NS, CLK_NS)),
                                 ns2cyc(T_RD_CYC_NS, CLK_NS));
    // One setup cycle precedes the pulse; selects count from that cycle.
    localparam int WE_CYC = imax(imax(ns2cyc(T_WE_PW_NS, CLK_NS),
                                      ns2cyc(T_SEL_WEND_NS, CLK_NS) - 1),
                                 imax(ns2cyc(T_D_SETUP_NS, CLK_NS), 1));
    localparam int WEND_CYC = imax(1, ns2cyc(T_WR_CYC_NS, CLK_NS) - 1 - WE_CYC);
    localparam int TURN_CYC = imax(1, ns2cyc(T_OE_REL_NS, CLK_NS));
    localparam int MAX_CYC  = imax(imax(RD_CYC, WE_CYC), imax(WEND_CYC, TURN_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic    idle, capture, start;
    strobe_t pins;

    assign start     = req_valid && idle;
    assign req_ready = idle;

    sramc_sequencer #(
        .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .WEND_CYC(WEND_CYC),
        .TURN_CYC(TURN_CYC), .IDLE_DESELECT(IDLE_DESELECT), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .start_wr(req_write),
        .idle(idle), .capture(capture), .pins(pins)
    );

    sramc_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk(clk), .rst(rst), .load(start), .ld_addr(req_addr),
        .ld_data(req_wdata), .capture(capture), .dq_in(mem_dq_in),
        .addr(mem_addr), .dq_out(mem_dq_out), .rdata(rsp_rdata),
        .rsp_valid(rsp_valid)
    );

    assign mem_ce1_n = !pins.sel;
    assign mem_ce2   = pins.sel;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.drv;

    assert_addr_steady_in_write_R5: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
    assert_rdata_held_R9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> $stable(rsp_rdata));
    assert_no_take_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(mem_addr) || $past(mem_we_n && mem_oe_n && !req_ready) || req_ready);

endmodule

// File: tb/test_async_sram_ctrl.sv
`timescale 1ns/1ps
module test_async_sram_ctrl;

    localparam int EXP_RD   = 14;
    localparam int EXP_WE   = 11;
    localparam int EXP_WTOT = 14;
    localparam int EXP_RTOT = 19;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in = 8'h5A;

    logic        b_ready, b_rsp, b_ce1_n, b_ce2, b_oe_n, b_we_n, b_dq_oe;
    logic [7:0]  b_rdata, b_dq_out;
    logic [16:0] b_addr;

    int checks = 0, errors = 0, cyc = 0;
    bit mon_on = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    async_sram_ctrl i_async_sram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    async_sram_ctrl #(.IDLE_DESELECT(1'b0)) i_async_sram_ctrl_sel (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(b_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(b_rsp), .rsp_rdata(b_rdata), .mem_addr(b_addr),
        .mem_ce1_n(b_ce1_n), .mem_ce2(b_ce2), .mem_oe_n(b_oe_n),
        .mem_we_n(b_we_n), .mem_dq_out(b_dq_out), .mem_dq_oe(b_dq_oe),
        .mem_dq_in(8'h00)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] dflt(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // Memory model: writes while selected with WE low, drives only when read-enabled.
    logic [7:0] mem [int];
    logic [7:0] shadow [int];
    wire sel = !mem_ce1_n && mem_ce2;
    always @(negedge clk) begin
        if (sel && !mem_we_n && mem_dq_oe) mem[int'(mem_addr)] = mem_dq_out;
        if (sel && !mem_oe_n && mem_we_n)
            mem_dq_in <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : dflt(mem_addr);
        else
            mem_dq_in <= 8'h5A;
    end

    // Pin-protocol monitor.
    logic        p_we_n = 1'b1, p_oe_n = 1'b1, p_sel = 1'b0, p_rsp = 1'b0;
    logic [16:0] p_addr = '0;
    logic [7:0]  p_dq = '0;
    int we_run = 0, oe_run = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            if ((!mem_we_n || !mem_oe_n) && !sel) check(1'b0, "R2 strobe while deselected", 0, 1);
            if (mem_dq_oe && mem_we_n) check(1'b0, "R5 drive with WE high", 1, 0);
            if (!mem_we_n) begin
                we_run++;
                if (!mem_oe_n) check(1'b0, "R5 OE low in write", 0, 1);
                if (p_we_n) check(p_sel, "R4 setup cycle selected", p_sel, 1);
                else if (mem_addr != p_addr || mem_dq_out != p_dq)
                    check(1'b0, "R5 addr/data moved", mem_addr, p_addr);
            end
            if (mem_we_n && !p_we_n) begin
                check(we_run == EXP_WE, "R4 WE pulse width", we_run, EXP_WE);
                we_run = 0;
            end
            if (!mem_oe_n) oe_run++;
            if (mem_oe_n && !p_oe_n) begin
                check(oe_run == EXP_RD, "R3 OE strobe width", oe_run, EXP_RD);
                oe_run = 0;
            end
            if (rsp_valid && p_rsp) check(1'b0, "R3 rsp pulse longer than 1", 2, 1);
        end
        p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_sel = sel; p_rsp = rsp_valid;
        p_addr = mem_addr; p_dq = mem_dq_out;
    end

    // Scoreboard monitor.
    logic [7:0] exp_q [$];
    int         due_q [$];
    logic [7:0] last_rd = '0;
    always @(negedge clk) begin
        if (mon_on && rsp_valid) begin
            if (exp_q.size() == 0) check(1'b0, "R3 unexpected response", 1, 0);
            else begin
                logic [7:0] e;
                int d;
                e = exp_q.pop_front();
                d = due_q.pop_front();
                check(rsp_rdata == e, "R3 read data", rsp_rdata, e);
                check(cyc == d, "R3 response cycle", cyc, d);
                last_rd = e;
            end
        end
    end

    task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
        int busy;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        if (wr) shadow[int'(a)] = d;
        else begin
            exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a));
            due_q.push_back(cyc + 1 + EXP_RD);
        end
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        while (!req_ready) begin busy++; @(negedge clk); end
        if (wr) check(busy == EXP_WTOT, "R6 write occupancy", busy, EXP_WTOT);
        else    check(busy == EXP_RTOT, "R7 read occupancy", busy, EXP_RTOT);
        check(mem_ce1_n && !mem_ce2, "R8 idle deselected", {mem_ce1_n, mem_ce2}, 2'b10);
        check(!b_ce1_n && b_ce2 && b_oe_n && b_we_n, "R8 idle kept selected",
              {b_ce1_n, b_ce2, b_oe_n, b_we_n}, 4'b0111);
    endtask

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(req_ready && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid && mem_ce1_n && !mem_ce2,
              "R1 state in reset", {req_ready, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid, mem_ce1_n, mem_ce2},
              7'b1110010);
        rst = 1'b0;
        mon_on = 1'b1;
        repeat (3) @(negedge clk);
        check(req_ready && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid && mem_ce1_n && !mem_ce2,
              "R1 state after reset", {req_ready, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid, mem_ce1_n, mem_ce2},
              7'b1110010);
        check(!b_ce1_n && b_ce2, "R8 selected idle after reset", {b_ce1_n, b_ce2}, 2'b01);

        issue(1'b0, 17'h00010, 8'h00);
        issue(1'b1, 17'h1FFFF, 8'hC3);
        issue(1'b0, 17'h1FFFF, 8'h00);
        issue(1'b1, 17'h00000, 8'h00);
        issue(1'b1, 17'h0AAAA, 8'hFF);
        issue(1'b0, 17'h00000, 8'h00);
        issue(1'b0, 17'h0AAAA, 8'h00);
        issue(1'b1, 17'h0AAAA, 8'h5A);
        issue(1'b0, 17'h0AAAA, 8'h00);
        issue(1'b1, 17'h15555, 8'h81);
        issue(1'b1, 17'h15555, 8'h7E);
        // R9: a write after the last read must leave rsp_rdata alone.
        check(rsp_rdata == last_rd, "R9 rdata held over writes", rsp_rdata, last_rd);
        issue(1'b0, 17'h15555, 8'h00);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
        check(rsp_rdata == 8'h7E, "R9 rdata after final read", rsp_rdata, 8'h7E);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule